// File: doc/BRIEF.md
# PCI Burst Write Initiator

This block is the initiator side of a 32-bit PCI memory-write burst. A local agent hands it a start address, a word count and a request-mode bit. The block then asks the arbiter for the bus and waits until it holds the grant and sees the bus idle. It drives one address phase carrying the memory-write command, then runs one data phase per word. Each data phase is paced by the target's ready signal. The words come from a small local buffer that the block indexes through `word_idx`.

A target may end the tenure early with STOP. In that case the block closes the tenure in a fixed order: FRAME drops first, then IRDY, then the bus is released. It then waits a fixed back-off and requests the bus again. The new tenure starts at the first word that was not moved. If no target claims the cycle within a bounded window, the tenure is closed in the same orderly way and an error pulse is raised. A clean finish raises a done pulse instead.

All bus signals are asserted high here; the pad ring supplies the low-active polarity and the tri-state enable comes from `ad_oe`.

Top module: `pciw_burst_master`

## Requirements
- R1: Out of reset, req, frame, irdy, ad_oe, par_oe, done, err and busy are all low.
- R2: A job_start is accepted only while idle and only with 1 <= job_len <= MAX_WORDS (default 4). A start with any other length, or a start while busy, is ignored. An accepted start drives req high in the next cycle.
- R3: The address phase begins in the cycle after a clock on which req, gnt and bus_idle are all high. In that phase frame=1, irdy=0, cbe=4'b0111 and ad = start address + 4 * words already moved. Each data phase then drives irdy=1, cbe=4'b0000 and ad = buffer word at word_idx.
- R4: A word is counted only on a clock where irdy and trdy are both high. While trdy is low, word_idx and ad hold their values.
- R5: frame is low during the final data phase while irdy is high. After that phase completes, frame, irdy and ad_oe are low in the next cycle, and done is high for exactly that one cycle.
- R6: With job_ext=0, req is low from the first cycle of the address phase.
- R7: With job_ext=1, req stays high through the address phase and the data phases until the next-to-last word of the tenure completes. For a one-word tenure, req drops at the address phase.
- R8: STOP during a data phase that is not the completing final word ends the tenure. The word still counts if trdy was high on that clock. The next cycle has frame=0 with irdy=1, the cycle after has irdy=0 with ad_oe=1, and ad_oe is low in the cycle after that.
- R9: After a STOP release with words left, req stays low for exactly BACKOFF (default 2) cycles starting at the release cycle, then rises.
- R10: par is driven (par_oe=1) in the cycle after each cycle with ad_oe=1. Its value makes the count of ones over the previous cycle's ad, cbe and par even.
- R11: If devsel is never seen during the first DEVSEL_LIMIT (default 5) data-phase clocks after the address phase, the tenure closes with the R8 frame/irdy sequence. err then pulses for one cycle and done does not pulse.
- R12: trdy during the frame=0/irdy=1 closing cycle after STOP moves no word. The resumed address phase carries the address of the first untransferred word, which is also shown on resume_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_start | input | 1 | Start a burst job (single-cycle pulse) |
| job_addr | input | 32 | Byte address of the first word |
| job_len | input | 3 | Number of words in the job |
| job_ext | input | 1 | 1 selects the extended request release |
| word_idx | output | 3 | Index of the word currently presented from the local buffer |
| word_data | input | 32 | Buffer word at word_idx |
| bus_idle | input | 1 | Bus observed idle (no FRAME, no IRDY) |
| gnt | input | 1 | Grant from the arbiter |
| devsel | input | 1 | Target claims the cycle |
| trdy | input | 1 | Target ready |
| stop | input | 1 | Target requests disconnect |
| req | output | 1 | Bus request |
| frame | output | 1 | Cycle frame |
| irdy | output | 1 | Initiator ready |
| ad_oe | output | 1 | Drive enable for ad and cbe |
| ad | output | 32 | Address/data bus |
| cbe | output | 4 | Command / byte enables (raw bus value) |
| par | output | 1 | Even parity over the previous cycle's ad and cbe |
| par_oe | output | 1 | Drive enable for par |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: job finished |
| err | output | 1 | One-cycle pulse: no target claimed the cycle |
| resume_addr | output | 32 | Address of the first word not yet moved |

## Verification
The assertions check several rules on every cycle. The word counter may step only on an irdy-and-trdy clock and must hold through wait states. A STOP must be followed by the frame-then-irdy-then-release order. req must stay low from the release cycle until the back-off ends. In extended mode req must stay high while two or more words remain. done and err must be single-cycle and mutually exclusive. Other behaviour can only be shown by the bench's scenarios, which compare every output against a reference model on every clock: the address carried by a resumed tenure, the exact back-off gap, the rejection of bad or overlapping starts, parity values, and the claim-timeout window length.

// File: rtl/pciw_pkg.sv
package pciw_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ASK,
      PH_ADDR,
      PH_DATA,
      PH_HOLD,
      PH_DROP,
      PH_WAIT
   } pciw_phase_e;

   localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;
   localparam logic [3:0] BE_ALL_BYTES  = 4'b0000;
endpackage

// File: rtl/pciw_addr_step.sv
module pciw_addr_step #(
   parameter int BUS_W = 32,
   parameter int CNT_W = 3,
   parameter int LANES = 4
) (
   input  logic [BUS_W-1:0] base,
   input  logic [CNT_W-1:0] moved,
   output logic [BUS_W-1:0] addr
);
   localparam int SHIFT = $clog2(LANES);

   initial begin
      assert (LANES > 0 && (1 << SHIFT) == LANES)
         else $error("pciw_addr_step: LANES must be a power of two");
   end

   assign addr = base + (BUS_W'(moved) << SHIFT);
endmodule

// File: rtl/pciw_parity.sv
module pciw_parity #(
   parameter int BUS_W = 32,
   parameter int CBE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drive,
   input  logic [BUS_W-1:0] ad,
   input  logic [CBE_W-1:0] cbe,
   output logic             par,
   output logic             par_oe
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par    <= 1'b0;
         par_oe <= 1'b0;
      end else begin
         par    <= drive ? ^{ad, cbe} : 1'b0;
         par_oe <= drive;
      end
   end
endmodule

// File: rtl/pciw_claim_watch.sv
module pciw_claim_watch #(
   parameter int LIMIT = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic live,
   input  logic devsel,
   output logic expired
);
   generate
      if (LIMIT == 0) begin : g_off
         logic unused_ok;
         assign unused_ok = &{clk, rst_n, arm, live, devsel};
         assign expired   = 1'b0;
      end else begin : g_timer
         localparam int CW = $clog2(LIMIT + 1);
         logic [CW-1:0] age_q;
         logic          seen_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               age_q  <= '0;
               seen_q <= 1'b0;
            end else if (arm) begin
               age_q  <= '0;
               seen_q <= 1'b0;
            end else if (live) begin
               seen_q <= seen_q | devsel;
               if (age_q != CW'(LIMIT)) age_q <= age_q + CW'(1);
            end
         end

         assign expired = live && !seen_q && !devsel && (age_q == CW'(LIMIT - 1));

         assert_claim_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (live && devsel) |=> !expired);
      end
   endgenerate
endmodule

// File: rtl/pciw_burst_master.sv
module pciw_burst_master
   import pciw_pkg::*;
#(
   parameter int BUS_W        = 32,
   parameter int MAX_WORDS    = 4,
   parameter int DEVSEL_LIMIT = 5,
   parameter int BACKOFF      = 2,
   localparam int CNT_W       = $clog2(MAX_WORDS + 1),
   localparam int CBE_W       = BUS_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             job_start,
   input  logic [BUS_W-1:0] job_addr,
   input  logic [CNT_W-1:0] job_len,
   input  logic             job_ext,
   output logic [CNT_W-1:0] word_idx,
   input  logic [BUS_W-1:0] word_data,
   input  logic             bus_idle,
   input  logic             gnt,
   input  logic             devsel,
   input  logic             trdy,
   input  logic             stop,
   output logic             req,
   output logic             frame,
   output logic             irdy,
   output logic             ad_oe,
   output logic [BUS_W-1:0] ad,
   output logic [CBE_W-1:0] cbe,
   output logic             par,
   output logic             par_oe,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic [BUS_W-1:0] resume_addr
);
   localparam int BO_W = (BACKOFF > 1) ? $clog2(BACKOFF) : 1;

   initial begin
      assert (BUS_W >= 32 && BUS_W % 8 == 0)
         else $error("pciw_burst_master: BUS_W must be a multiple of 8, at least 32");
      assert (MAX_WORDS >= 1) else $error("pciw_burst_master: MAX_WORDS must be >= 1");
      assert (BACKOFF >= 1) else $error("pciw_burst_master: BACKOFF must be >= 1");
      assert (DEVSEL_LIMIT >= 0) else $error("pciw_burst_master: DEVSEL_LIMIT negative");
   end

   pciw_phase_e      ph_q;
   logic [CNT_W-1:0] sent_q, left_q;
   logic [BUS_W-1:0] base_q;
   logic             ext_q, abort_q, done_q, err_q;
   logic [BO_W-1:0]  bo_q;
   logic             claim_lost, xfer, accept, last_word;
   logic [BUS_W-1:0] cur_addr;

   assign accept    = job_start && (ph_q == PH_IDLE) && (job_len != '0)
                      && (job_len <= CNT_W'(MAX_WORDS));
   assign xfer      = (ph_q == PH_DATA) && trdy;
   assign last_word = (left_q == CNT_W'(1));

   pciw_addr_step #(.BUS_W(BUS_W), .CNT_W(CNT_W), .LANES(CBE_W)) u_step (
      .base  (base_q),
      .moved (sent_q),
      .addr  (cur_addr)
   );

   pciw_claim_watch #(.LIMIT(DEVSEL_LIMIT)) u_claim (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (ph_q == PH_ADDR),
      .live    (ph_q == PH_DATA),
      .devsel  (devsel),
      .expired (claim_lost)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         sent_q  <= '0;
         left_q  <= '0;
         base_q  <= '0;
         ext_q   <= 1'b0;
         abort_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         bo_q    <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (ph_q)
            PH_IDLE: if (accept) begin
               base_q  <= job_addr;
               left_q  <= job_len;
               sent_q  <= '0;
               ext_q   <= job_ext;
               abort_q <= 1'b0;
               ph_q    <= PH_ASK;
            end
            PH_ASK:  if (gnt && bus_idle) ph_q <= PH_ADDR;
            PH_ADDR: ph_q <= PH_DATA;
            PH_DATA: begin
               if (xfer) begin
                  sent_q <= sent_q + CNT_W'(1);
                  left_q <= left_q - CNT_W'(1);
               end
               if (xfer && last_word) begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end else if (stop) begin
                  ph_q <= PH_HOLD;
               end else if (claim_lost) begin
                  ph_q    <= PH_HOLD;
                  abort_q <= 1'b1;
               end
            end
            PH_HOLD: ph_q <= PH_DROP;
            PH_DROP: if (abort_q) begin
               ph_q  <= PH_IDLE;
               err_q <= 1'b1;
            end else begin
               ph_q <= PH_WAIT;
               bo_q <= '0;
            end
            PH_WAIT: if (bo_q == BO_W'(BACKOFF - 1)) ph_q <= PH_ASK;
                     else bo_q <= bo_q + BO_W'(1);
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      req   = (ph_q == PH_ASK)
              || (ext_q && (ph_q == PH_ADDR || ph_q == PH_DATA) && (left_q > CNT_W'(1)));
      frame = (ph_q == PH_ADDR) || ((ph_q == PH_DATA) && !last_word);
      irdy  = (ph_q == PH_DATA) || (ph_q == PH_HOLD);
      ad_oe = (ph_q == PH_ADDR) || irdy || (ph_q == PH_DROP);
      if (ph_q == PH_ADDR) begin
         ad  = cur_addr;
         cbe = CBE_W'(CMD_MEM_WRITE);
      end else if (ad_oe) begin
         ad  = word_data;
         cbe = CBE_W'(BE_ALL_BYTES);
      end else begin
         ad  = '0;
         cbe = '0;
      end
   end

   pciw_parity #(.BUS_W(BUS_W), .CBE_W(CBE_W)) u_par (
      .clk    (clk),
      .rst_n  (rst_n),
      .drive  (ad_oe),
      .ad     (ad),
      .cbe    (cbe),
      .par    (par),
      .par_oe (par_oe)
   );

   assign word_idx    = sent_q;
   assign busy        = (ph_q != PH_IDLE);
   assign done        = done_q;
   assign err         = err_q;
   assign resume_addr = cur_addr;

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DATA && trdy) |=> (sent_q == $past(sent_q) + CNT_W'(1)));

   assert_wait_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DATA && !trdy) |=> $stable(sent_q));

   assert_final_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irdy && frame && trdy && !stop && left_q == CNT_W'(2)) |=> (!frame && irdy));

   assert_ext_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_q && ph_q == PH_DATA && left_q > CNT_W'(1)) |-> req);

   assert_stop_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DATA && stop && !(trdy && last_word))
      |=> (!frame && irdy) ##1 (!irdy && ad_oe) ##1 !ad_oe);

   assert_release_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ad_oe) && busy) |-> !req);

   assert_backoff_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_WAIT && bo_q == BO_W'(BACKOFF - 1)) |=> req);

   assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> (!(done && err) && !busy));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/pciw_burst_master_test.sv
module pciw_burst_master_test;
   localparam int MAXW = 4;
   localparam int CW   = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          job_start, job_ext;
   logic [31:0]   job_addr;
   logic [CW-1:0] job_len;
   logic [CW-1:0] word_idx;
   logic [31:0]   word_data;
   logic          bus_idle, gnt, devsel, trdy, stop;
   logic          req, frame, irdy, ad_oe, par, par_oe, busy, done, err;
   logic [31:0]   ad, resume_addr;
   logic [3:0]    cbe;
   logic [31:0]   mem [0:7];

   always #5 clk = ~clk;
   assign word_data = mem[word_idx];

   pciw_burst_master uut (
      .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_addr(job_addr),
      .job_len(job_len), .job_ext(job_ext), .word_idx(word_idx), .word_data(word_data),
      .bus_idle(bus_idle), .gnt(gnt), .devsel(devsel), .trdy(trdy), .stop(stop),
      .req(req), .frame(frame), .irdy(irdy), .ad_oe(ad_oe), .ad(ad), .cbe(cbe),
      .par(par), .par_oe(par_oe), .busy(busy), .done(done), .err(err),
      .resume_addr(resume_addr)
   );

   int    n_tests = 0, n_fail = 0;
   string tag = "R1";

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s] %s act=%h exp=%h", rq, tag, what, act, exp);
      end
   endtask

   // reference model: 0 idle 1 asking 2 address 3 data 4 hold 5 drop 6 back-off
   int          m_ph, m_left, m_sent, m_back, m_age;
   bit          m_claimed, m_ext, m_abort, m_done, m_err, m_par, m_paroe;
   logic [31:0] m_base;

   function automatic bit e_oe();    return m_ph >= 2 && m_ph <= 5; endfunction
   function automatic bit e_frame(); return m_ph == 2 || (m_ph == 3 && m_left > 1); endfunction
   function automatic bit e_irdy();  return m_ph == 3 || m_ph == 4; endfunction
   function automatic bit e_req();
      return m_ph == 1 || (m_ext && (m_ph == 2 || m_ph == 3) && m_left > 1);
   endfunction
   function automatic logic [31:0] e_ad();
      if (m_ph == 2) return m_base + 32'(4 * m_sent);
      if (e_oe()) return mem[m_sent];
      return 32'h0;
   endfunction
   function automatic logic [3:0] e_cbe(); return (m_ph == 2) ? 4'b0111 : 4'b0000; endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_sent = 0; m_back = 0; m_age = 0; m_base = 0;
         m_claimed = 0; m_ext = 0; m_abort = 0; m_done = 0; m_err = 0; m_par = 0; m_paroe = 0;
      end else begin
         m_paroe = e_oe();
         m_par   = e_oe() ? ^{e_ad(), e_cbe()} : 1'b0;
         m_done = 0; m_err = 0;
         case (m_ph)
            0: if (job_start && job_len >= 1 && job_len <= MAXW) begin
                  m_base = job_addr; m_left = int'(job_len); m_sent = 0;
                  m_ext = job_ext; m_abort = 0; m_ph = 1;
               end
            1: if (gnt && bus_idle) m_ph = 2;
            2: begin m_ph = 3; m_claimed = 0; m_age = 1; end
            3: begin
               if (trdy) begin m_sent++; m_left--; end
               if (trdy && m_left == 0) begin m_ph = 0; m_done = 1; end
               else if (stop) m_ph = 4;
               else if (!m_claimed && !devsel && m_age >= 5) begin m_ph = 4; m_abort = 1; end
               else begin if (devsel) m_claimed = 1; m_age++; end
            end
            4: m_ph = 5;
            5: if (m_abort) begin m_ph = 0; m_err = 1; end else begin m_ph = 6; m_back = 0; end
            6: begin m_back++; if (m_back == 2) m_ph = 1; end
            default: m_ph = 0;
         endcase
      end
   end

   // target / arbiter configuration
   int  cfg_wait = 0, cfg_stop_at = -1, busy_hold = 0, wait_left = 0;
   bit  cfg_stop_nodata = 0, cfg_trdy_hold = 0, cfg_nodev = 0, in_stop = 0, compare_on = 0;
   int  ncyc = 0, rel_at = -1, last_gap = -1;
   bit  prev_oe = 0, prev_req = 0;
   logic [31:0] last_addr = 0;

   always @(negedge clk) begin
      if (compare_on) begin
         chk(req === e_req(), m_ext ? "R7" : "R6", "req", 32'(req), 32'(e_req()));
         chk(frame === e_frame(), "R5", "frame", 32'(frame), 32'(e_frame()));
         chk(irdy === e_irdy(), "R8", "irdy", 32'(irdy), 32'(e_irdy()));
         chk(ad_oe === e_oe(), "R8", "ad_oe", 32'(ad_oe), 32'(e_oe()));
         chk(ad === e_ad(), "R3", "ad", ad, e_ad());
         chk(cbe === e_cbe(), "R3", "cbe", 32'(cbe), 32'(e_cbe()));
         chk(par === m_par && par_oe === m_paroe, "R10", "par,par_oe",
             {30'd0, par, par_oe}, {30'd0, m_par, m_paroe});
         chk(done === m_done, "R5", "done", 32'(done), 32'(m_done));
         chk(err === m_err, "R11", "err", 32'(err), 32'(m_err));
         chk(busy === (m_ph != 0), "R2", "busy", 32'(busy), 32'(m_ph != 0));
         chk(word_idx === CW'(m_sent), "R4", "word_idx", 32'(word_idx), 32'(m_sent));
         chk(resume_addr === m_base + 32'(4 * m_sent), "R12", "resume_addr",
             resume_addr, m_base + 32'(4 * m_sent));
      end
      // trackers for back-off gap and address phases
      if (prev_oe && !ad_oe && busy) rel_at = ncyc;
      if (!prev_req && req && rel_at >= 0) begin last_gap = ncyc - rel_at; rel_at = -1; end
      if (frame && !irdy) last_addr = ad;
      prev_oe = ad_oe; prev_req = req; ncyc++;
      // arbiter and target responder
      gnt      = req;
      bus_idle = (busy_hold == 0);
      if (busy_hold > 0) busy_hold--;
      if (frame && !irdy) begin wait_left = cfg_wait; in_stop = 0; end
      devsel = irdy && !cfg_nodev;
      stop = 1'b0; trdy = 1'b0;
      if (irdy && !cfg_nodev) begin
         if (in_stop) begin stop = 1'b1; trdy = cfg_trdy_hold; end
         else if (wait_left > 0) wait_left--;
         else if (int'(word_idx) == cfg_stop_at) begin
            stop = 1'b1; trdy = !cfg_stop_nodata; in_stop = 1; cfg_stop_at = -1;
         end else trdy = 1'b1;
      end
   end

   task automatic pulse_start(input logic [31:0] a, input int len, input bit ext);
      @(negedge clk);
      job_addr = a; job_len = CW'(len); job_ext = ext; job_start = 1'b1;
      @(negedge clk);
      job_start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic run_job(input logic [31:0] a, input int len, input bit ext, input string t);
      tag = t;
      pulse_start(a, len, ext);
      wait_idle();
   endtask

   initial begin
      for (int i = 0; i < 8; i++) mem[i] = 32'hA5C3_0000 ^ (32'h1111_1111 * (i + 1));
      rst_n = 1'b0; job_start = 0; job_addr = 0; job_len = 0; job_ext = 0;
      gnt = 0; bus_idle = 1; devsel = 0; trdy = 0; stop = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tag = "R1";
      chk({req, frame, irdy, ad_oe, par_oe, done, err, busy} === 8'h00, "R1", "reset outputs",
          {24'd0, req, frame, irdy, ad_oe, par_oe, done, err, busy}, 32'h0);
      compare_on = 1;

      run_job(32'h0000_4000, 0, 0, "R2");
      run_job(32'h0000_4000, 5, 0, "R2");
      chk(last_addr === 32'h0, "R2", "no address phase for bad length", last_addr, 32'h0);

      cfg_wait = 1;
      run_job(32'h0001_0000, 4, 0, "R3");
      chk(last_addr === 32'h0001_0000, "R3", "address phase", last_addr, 32'h0001_0000);
      cfg_wait = 2;
      run_job(32'h0001_0100, 3, 0, "R4");
      cfg_wait = 0;
      run_job(32'h0001_0200, 4, 1, "R7");
      run_job(32'h0001_0300, 1, 1, "R7");
      run_job(32'h0001_0400, 2, 0, "R6");
      run_job(32'h0001_0500, 1, 0, "R5");

      busy_hold = 4;
      run_job(32'h0001_0600, 2, 0, "R3");

      tag = "R2";
      pulse_start(32'h0002_0000, 4, 0);
      repeat (2) @(negedge clk);
      pulse_start(32'h0002_8000, 2, 1);
      wait_idle();
      chk(last_addr === 32'h0002_0000, "R2", "start while busy ignored", last_addr, 32'h0002_0000);

      cfg_stop_at = 1; cfg_trdy_hold = 1;
      run_job(32'h0000_1000, 4, 0, "R8");
      chk(last_addr === 32'h0000_1008, "R12", "resume after stop with data", last_addr, 32'h0000_1008);
      chk(last_gap == 2, "R9", "back-off gap", 32'(last_gap), 32'd2);

      cfg_stop_at = 2; cfg_stop_nodata = 1; cfg_trdy_hold = 0;
      run_job(32'h0000_2000, 3, 1, "R8");
      chk(last_addr === 32'h0000_2008, "R12", "resume after stop without data", last_addr, 32'h0000_2008);
      chk(last_gap == 2, "R9", "back-off gap", 32'(last_gap), 32'd2);
      cfg_stop_nodata = 0;

      cfg_nodev = 1;
      run_job(32'h0000_3000, 3, 0, "R11");
      cfg_nodev = 0;
      run_job(32'h0000_3100, 2, 1, "R10");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 50000) begin
         n_fail++;
         $display("FAIL watchdog [%s] act=%0d exp=<50000", tag, wd);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule